// File: doc/BRIEF.md
# Workgroup Wave Launcher with Register Seeding

This block takes one workgroup (its three-dimensional ID, its three extents, a 64-bit kernel-argument pointer and a 32-bit configuration word) and cuts it into waves of 32 lanes. For every wave in turn it emits the register values the wave must start with: the lane-enable mask, the two halves of the argument pointer, the enabled workgroup IDs, and one packed thread coordinate per live lane. These go out as a stream of one register write per cycle, with a pulse that marks the start of each wave and a pulse when the whole workgroup has been emitted.

A launcher upstream pulses `start` with the workgroup description. A wave-slot loader downstream consumes the write stream and tags the writes by the wave number that accompanies the start pulse. Executing the waves is not part of this block. Thread coordinates come from carry-chained counters, so no divider is needed.

Top module: `wg_wave_dispatch`

## Requirements
- R1: The thread count is size_x·size_y·size_z. Waves are numbered 0, 1, 2, … and cover threads in blocks of 32. Every wave except the last has 32 lanes, and the last has the remainder (1 to 32).
- R2: A wave begins with one write of kind 0 (mask) whose data is (1 << lanes) − 1, with bit i set for each live lane i. `wave_start` is high in that same cycle and `wave_num` carries the wave number.
- R3: After the mask write come two cycles of kind 1 (scalar) writes: index 0 with arg_ptr[31:0], then index 1 with arg_ptr[63:32].
- R4: Three cycles follow, one per dimension in the order x, y, z. Bits 7, 8 and 9 of cfg_word enable x, y and z. An enabled dimension writes a kind 1 register at index cfg_word[5:1] plus the number of enabled dimensions before it, with that dimension's workgroup ID as data. A disabled dimension's cycle has `wr_valid` low.
- R5: Each live lane i then gets, in lane order and one per cycle, a kind 2 (vector) write with index 0 and `wr_lane` = i. With tid = 32·wave + i, the data is (z << 20) | (y << 10) | x, where x = tid mod size_x, y = (tid / size_x) mod size_y and z = tid / (size_x·size_y).
- R6: Each extent may be from 1 to 1024. The x, y and z fields each occupy 10 bits and can reach 1023.
- R7: `done` is high for exactly one cycle, the cycle of the final lane write of the last wave. In the next cycle `busy`, `wr_valid` and `done` are low.
- R8: If any extent is zero, no write is emitted. `done` pulses in the cycle after `start` is taken.
- R9: A `start` pulse while `busy` is high is ignored. The stream in progress continues unchanged.
- R10: After reset, `busy`, `wr_valid`, `wave_start` and `done` are low.
- R11: A `start` sampled while idle causes the first mask write to appear in the next cycle. `busy` stays high until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| wg_id_x | input | 32 | Workgroup ID, x |
| wg_id_y | input | 32 | Workgroup ID, y |
| wg_id_z | input | 32 | Workgroup ID, z |
| size_x | input | 11 | Extent in x (1..1024) |
| size_y | input | 11 | Extent in y (1..1024) |
| size_z | input | 11 | Extent in z (1..1024) |
| arg_ptr | input | 64 | Kernel argument pointer |
| cfg_word | input | 32 | Configuration word: [5:1] ID base register, [9:7] ID enables |
| busy | output | 1 | A workgroup is being emitted |
| wave_start | output | 1 | First cycle of a wave (mask write) |
| wave_num | output | 26 | Number of the current wave |
| wr_valid | output | 1 | A register write is present |
| wr_kind | output | 2 | 0 mask, 1 scalar, 2 vector |
| wr_index | output | 8 | Register index |
| wr_lane | output | 5 | Lane of a vector write |
| wr_data | output | 32 | Write data |
| done | output | 1 | Final write of the workgroup |

## Verification
The completion pulse and the last lane write of the final wave share one cycle, and in an all-zero launch the completion pulse has no write at all. The bench builds cycle-exact expected streams in which `done` is set only on the last lane entry (or on the lone idle entry of a zero-extent launch). It drives sizes that are exact multiples of 32 as well as ones that leave a single-lane tail, and compares `done`, `wr_valid` and the data together in every cycle. A second `start` is injected in the middle of a run to confirm it cannot restart the stream or cut it short.

// File: rtl/wdisp_pkg.sv
package wdisp_pkg;

  localparam int FIELD_W   = 10;
  localparam int Y_SHIFT   = 10;
  localparam int Z_SHIFT   = 20;
  localparam int CFG_BASE_LSB = 1;
  localparam int CFG_BASE_W   = 5;
  localparam int CFG_EN_LSB   = 7;

  typedef enum logic [1:0] {
    WR_MASK = 2'd0,
    WR_SREG = 2'd1,
    WR_VREG = 2'd2
  } wr_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MASK,
    ST_PLO,
    ST_PHI,
    ST_WGID,
    ST_LANE,
    ST_EMPTY
  } disp_state_e;

  // packs one thread coordinate triple into the vector register word
  function automatic logic [31:0] pack_coord(input logic [FIELD_W-1:0] x,
                                             input logic [FIELD_W-1:0] y,
                                             input logic [FIELD_W-1:0] z);
    return (32'(z) << Z_SHIFT) | (32'(y) << Y_SHIFT) | 32'(x);
  endfunction

  // number of enabled dimensions strictly below dim
  function automatic logic [1:0] enabled_below(input logic [2:0] en,
                                               input logic [1:0] dim);
    logic [1:0] n;
    n = 2'd0;
    for (int k = 0; k < 3; k++)
      if (k < int'(dim) && en[k]) n = n + 2'd1;
    return n;
  endfunction

endpackage

// File: rtl/wave_sizer.sv
module wave_sizer #(
  parameter int LANES = 32,
  parameter int REM_W = 31,
  localparam int LANE_CNT_W = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active_i,
  input  logic [REM_W-1:0]      rem_i,
  output logic [LANE_CNT_W-1:0] lanes_o,
  output logic [LANES-1:0]      mask_o,
  output logic                  last_o
);

  logic full_wave;
  assign full_wave = (rem_i >= REM_W'(LANES));
  assign lanes_o   = full_wave ? LANE_CNT_W'(LANES) : rem_i[LANE_CNT_W-1:0];
  assign last_o    = (rem_i <= REM_W'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign mask_o[i] = (LANE_CNT_W'(i) < lanes_o);
  end

  // mask bit count equals the lane count of the wave
  assert_mask_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> ($countones(mask_o) == int'(lanes_o)));

  // mask bits are contiguous from lane 0
  assert_mask_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (((mask_o + LANES'(1)) & mask_o) == '0 && mask_o[0]));

endmodule

// File: rtl/coord_walker.sv
module coord_walker
  import wdisp_pkg::*;
#(
  parameter int DIM_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic [DIM_W-1:0]   ext_x_i,
  input  logic [DIM_W-1:0]   ext_y_i,
  output logic [FIELD_W-1:0] x_o,
  output logic [FIELD_W-1:0] y_o,
  output logic [FIELD_W-1:0] z_o
);

  logic x_wrap, y_wrap;
  assign x_wrap = (DIM_W'(x_o) == ext_x_i - DIM_W'(1));
  assign y_wrap = (DIM_W'(y_o) == ext_y_i - DIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else if (step_i) begin
      if (x_wrap) begin
        x_o <= '0;
        if (y_wrap) begin
          y_o <= '0;
          z_o <= z_o + FIELD_W'(1);
        end else begin
          y_o <= y_o + FIELD_W'(1);
        end
      end else begin
        x_o <= x_o + FIELD_W'(1);
      end
    end
  end

  assert_x_below_extent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && ext_x_i != '0) |-> (DIM_W'(x_o) < ext_x_i));

  assert_y_below_extent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && ext_y_i != '0) |-> (DIM_W'(y_o) < ext_y_i));

endmodule

// File: rtl/sreg_planner.sv
module sreg_planner
  import wdisp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIDX_W = 8
) (
  input  logic [CFG_BASE_W-1:0] base_i,
  input  logic [2:0]            en_i,
  input  logic [1:0]            dim_i,
  input  logic [DATA_W-1:0]     id_x_i,
  input  logic [DATA_W-1:0]     id_y_i,
  input  logic [DATA_W-1:0]     id_z_i,
  output logic                  wr_en_o,
  output logic [SIDX_W-1:0]     idx_o,
  output logic [DATA_W-1:0]     data_o
);

  always_comb begin
    wr_en_o = 1'b0;
    data_o  = '0;
    case (dim_i)
      2'd0: begin wr_en_o = en_i[0]; data_o = id_x_i; end
      2'd1: begin wr_en_o = en_i[1]; data_o = id_y_i; end
      2'd2: begin wr_en_o = en_i[2]; data_o = id_z_i; end
      default: begin wr_en_o = 1'b0; data_o = '0; end
    endcase
    idx_o = SIDX_W'(base_i) + SIDX_W'(enabled_below(en_i, dim_i));
  end

endmodule

// File: rtl/wg_wave_dispatch.sv
module wg_wave_dispatch
  import wdisp_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int DIM_W  = FIELD_W + 1,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 64,
  parameter int SIDX_W = 8,
  localparam int LANE_W     = $clog2(LANES),
  localparam int LANE_CNT_W = $clog2(LANES + 1),
  localparam int PROD_W     = 3 * DIM_W,
  localparam int TOTAL_W    = 3 * FIELD_W + 1,
  localparam int WAVE_NUM_W = TOTAL_W - LANE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DATA_W-1:0]     wg_id_x,
  input  logic [DATA_W-1:0]     wg_id_y,
  input  logic [DATA_W-1:0]     wg_id_z,
  input  logic [DIM_W-1:0]      size_x,
  input  logic [DIM_W-1:0]      size_y,
  input  logic [DIM_W-1:0]      size_z,
  input  logic [PTR_W-1:0]      arg_ptr,
  input  logic [31:0]           cfg_word,
  output logic                  busy,
  output logic                  wave_start,
  output logic [WAVE_NUM_W-1:0] wave_num,
  output logic                  wr_valid,
  output logic [1:0]            wr_kind,
  output logic [SIDX_W-1:0]     wr_index,
  output logic [LANE_W-1:0]     wr_lane,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  done
);

  disp_state_e             state_q;
  logic [DIM_W-1:0]        ext_x_q, ext_y_q;
  logic [DATA_W-1:0]       id_x_q, id_y_q, id_z_q;
  logic [PTR_W-1:0]        ptr_q;
  logic [CFG_BASE_W-1:0]   base_q;
  logic [2:0]              en_q;
  logic [TOTAL_W-1:0]      rem_q;
  logic [WAVE_NUM_W-1:0]   wave_q;
  logic [LANE_W-1:0]       lane_q;
  logic [1:0]              dim_q;

  // named internal events
  logic                    take_start;
  logic [PROD_W-1:0]       prod_w;
  logic [TOTAL_W-1:0]      total_w;
  logic [LANE_CNT_W-1:0]   wave_lanes;
  logic [LANES-1:0]        wave_mask;
  logic                    wave_is_last;
  logic                    lane_is_last;
  logic                    lane_step;
  logic [FIELD_W-1:0]      cx, cy, cz;
  logic                    slot_en;
  logic [SIDX_W-1:0]       slot_idx;
  logic [DATA_W-1:0]       slot_data;

  assign take_start   = start && (state_q == ST_IDLE);
  assign prod_w       = PROD_W'(size_x) * PROD_W'(size_y) * PROD_W'(size_z);
  assign total_w      = prod_w[TOTAL_W-1:0];
  assign lane_is_last = (LANE_CNT_W'(lane_q) == wave_lanes - LANE_CNT_W'(1));
  assign lane_step    = (state_q == ST_LANE);

  wave_sizer #(.LANES(LANES), .REM_W(TOTAL_W)) u_sizer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (state_q == ST_MASK),
    .rem_i    (rem_q),
    .lanes_o  (wave_lanes),
    .mask_o   (wave_mask),
    .last_o   (wave_is_last)
  );

  coord_walker #(.DIM_W(DIM_W)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (take_start),
    .step_i  (lane_step),
    .ext_x_i (ext_x_q),
    .ext_y_i (ext_y_q),
    .x_o     (cx),
    .y_o     (cy),
    .z_o     (cz)
  );

  sreg_planner #(.DATA_W(DATA_W), .SIDX_W(SIDX_W)) u_planner (
    .base_i  (base_q),
    .en_i    (en_q),
    .dim_i   (dim_q),
    .id_x_i  (id_x_q),
    .id_y_i  (id_y_q),
    .id_z_i  (id_z_q),
    .wr_en_o (slot_en),
    .idx_o   (slot_idx),
    .data_o  (slot_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ext_x_q <= '0;
      ext_y_q <= '0;
      id_x_q  <= '0;
      id_y_q  <= '0;
      id_z_q  <= '0;
      ptr_q   <= '0;
      base_q  <= '0;
      en_q    <= '0;
      rem_q   <= '0;
      wave_q  <= '0;
      lane_q  <= '0;
      dim_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            ext_x_q <= size_x;
            ext_y_q <= size_y;
            id_x_q  <= wg_id_x;
            id_y_q  <= wg_id_y;
            id_z_q  <= wg_id_z;
            ptr_q   <= arg_ptr;
            base_q  <= cfg_word[CFG_BASE_LSB +: CFG_BASE_W];
            en_q    <= cfg_word[CFG_EN_LSB +: 3];
            rem_q   <= total_w;
            wave_q  <= '0;
            state_q <= (total_w == '0) ? ST_EMPTY : ST_MASK;
          end
        end
        ST_MASK:  state_q <= ST_PLO;
        ST_PLO:   state_q <= ST_PHI;
        ST_PHI: begin
          dim_q   <= 2'd0;
          state_q <= ST_WGID;
        end
        ST_WGID: begin
          if (dim_q == 2'd2) begin
            lane_q  <= '0;
            state_q <= ST_LANE;
          end else begin
            dim_q <= dim_q + 2'd1;
          end
        end
        ST_LANE: begin
          if (lane_is_last) begin
            if (wave_is_last) begin
              state_q <= ST_IDLE;
            end else begin
              rem_q   <= rem_q - TOTAL_W'(LANES);
              wave_q  <= wave_q + WAVE_NUM_W'(1);
              state_q <= ST_MASK;
            end
          end else begin
            lane_q <= lane_q + LANE_W'(1);
          end
        end
        ST_EMPTY: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_valid = 1'b0;
    wr_kind  = WR_MASK;
    wr_index = '0;
    wr_lane  = '0;
    wr_data  = '0;
    case (state_q)
      ST_MASK: begin
        wr_valid = 1'b1;
        wr_kind  = WR_MASK;
        wr_data  = DATA_W'(wave_mask);
      end
      ST_PLO: begin
        wr_valid = 1'b1;
        wr_kind  = WR_SREG;
        wr_index = SIDX_W'(0);
        wr_data  = ptr_q[DATA_W-1:0];
      end
      ST_PHI: begin
        wr_valid = 1'b1;
        wr_kind  = WR_SREG;
        wr_index = SIDX_W'(1);
        wr_data  = ptr_q[PTR_W-1:DATA_W];
      end
      ST_WGID: begin
        wr_valid = slot_en;
        wr_kind  = WR_SREG;
        wr_index = slot_idx;
        wr_data  = slot_data;
      end
      ST_LANE: begin
        wr_valid = 1'b1;
        wr_kind  = WR_VREG;
        wr_lane  = lane_q;
        wr_data  = pack_coord(cx, cy, cz);
      end
      default: ;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign wave_start = (state_q == ST_MASK);
  assign wave_num   = wave_q;
  assign done       = (state_q == ST_EMPTY) || (lane_step && lane_is_last && wave_is_last);

  assert_lane_in_wave_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LANE) |-> (LANE_CNT_W'(lane_q) < wave_lanes));

  assert_wave_start_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wave_start |-> (wr_valid && wr_kind == WR_MASK && wr_data[0]));

  assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !wr_valid && !done));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ptr_q) && $stable(ext_x_q) && $stable(wave_q)));

  assert_first_is_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_start && total_w != '0) |=> wave_start);

endmodule

// File: tb/sim_wg_wave_dispatch.sv
`timescale 1ns/1ps
module sim_wg_wave_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] wg_id_x = '0, wg_id_y = '0, wg_id_z = '0;
  logic [10:0] size_x = '0, size_y = '0, size_z = '0;
  logic [63:0] arg_ptr = '0;
  logic [31:0] cfg_word = '0;
  logic        busy, wave_start, wr_valid, done;
  logic [25:0] wave_num;
  logic [1:0]  wr_kind;
  logic [7:0]  wr_index;
  logic [4:0]  wr_lane;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  wg_wave_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wg_id_x(wg_id_x), .wg_id_y(wg_id_y), .wg_id_z(wg_id_z),
    .size_x(size_x), .size_y(size_y), .size_z(size_z),
    .arg_ptr(arg_ptr), .cfg_word(cfg_word),
    .busy(busy), .wave_start(wave_start), .wave_num(wave_num),
    .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_index(wr_index),
    .wr_lane(wr_lane), .wr_data(wr_data), .done(done)
  );

  typedef struct {
    logic        v;
    logic [1:0]  k;
    logic [7:0]  idx;
    logic [4:0]  lane;
    logic [31:0] data;
    logic        ws;
    logic [25:0] wn;
    logic        dn;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic int exp_coord(int tid, int lx, int ly);
    int x, y, z;
    x = tid % lx;
    y = (tid / lx) % ly;
    z = tid / (lx * ly);
    return (z << 20) | (y << 10) | x;
  endfunction

  function automatic exp_t mk(logic v, logic [1:0] k, int idx, int lane, logic [31:0] d,
                              logic ws, int wn, logic dn, string tag);
    exp_t e;
    e.v = v; e.k = k; e.idx = 8'(idx); e.lane = 5'(lane); e.data = d;
    e.ws = ws; e.wn = 26'(wn); e.dn = dn; e.tag = tag;
    return e;
  endfunction

  task automatic build(int lx, int ly, int lz, logic [31:0] ix, logic [31:0] iy,
                       logic [31:0] iz, logic [63:0] p, logic [31:0] cfg);
    int total, nw, n, k, base;
    logic [31:0] ids [3];
    q.delete();
    ids[0] = ix; ids[1] = iy; ids[2] = iz;
    total = lx * ly * lz;
    base = int'(cfg[5:1]);
    if (total == 0) begin
      q.push_back(mk(1'b0, 2'd0, 0, 0, 32'd0, 1'b0, 0, 1'b1, "R8"));
      return;
    end
    nw = (total + 31) / 32;
    for (int w = 0; w < nw; w++) begin
      n = (total - 32 * w > 32) ? 32 : total - 32 * w;
      q.push_back(mk(1'b1, 2'd0, 0, 0, (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1),
                     1'b1, w, 1'b0, (w == 0) ? "R11" : "R2"));
      q.push_back(mk(1'b1, 2'd1, 0, 0, p[31:0], 1'b0, w, 1'b0, "R3"));
      q.push_back(mk(1'b1, 2'd1, 1, 0, p[63:32], 1'b0, w, 1'b0, "R3"));
      k = 0;
      for (int d = 0; d < 3; d++) begin
        if (cfg[7 + d]) begin
          q.push_back(mk(1'b1, 2'd1, base + k, 0, ids[d], 1'b0, w, 1'b0, "R4"));
          k++;
        end else begin
          q.push_back(mk(1'b0, 2'd0, 0, 0, 32'd0, 1'b0, w, 1'b0, "R4"));
        end
      end
      for (int i = 0; i < n; i++) begin
        logic last;
        last = (w == nw - 1) && (i == n - 1);
        q.push_back(mk(1'b1, 2'd2, 0, i, 32'(exp_coord(32 * w + i, lx, ly)), 1'b0, w, last,
                       last ? "R7" : ((lx == 1024 || ly == 1024 || lz == 1024) ? "R6" : "R5")));
      end
    end
  endtask

  task automatic check_entry(exp_t e);
    bit bad;
    checks++;
    bad = (wr_valid !== e.v) || (done !== e.dn) || (wave_start !== e.ws);
    if (e.v)
      bad = bad || (wr_kind !== e.k) || (wr_index !== e.idx) || (wr_data !== e.data) ||
            (e.k == 2'd2 && wr_lane !== e.lane);
    if (e.ws) bad = bad || (wave_num !== e.wn);
    if (bad) begin
      errors++;
      $display("FAIL %s: got v%0b k%0d i%0d l%0d d%h ws%0b wn%0d dn%0b exp v%0b k%0d i%0d l%0d d%h ws%0b wn%0d dn%0b",
               e.tag, wr_valid, wr_kind, wr_index, wr_lane, wr_data, wave_start, wave_num, done,
               e.v, e.k, e.idx, e.lane, e.data, e.ws, e.wn, e.dn);
    end
  endtask

  task automatic run_job(int lx, int ly, int lz, logic [31:0] ix, logic [31:0] iy,
                         logic [31:0] iz, logic [63:0] p, logic [31:0] cfg, bit inject);
    int err0;
    build(lx, ly, lz, ix, iy, iz, p, cfg);
    err0 = errors;
    @(negedge clk);
    size_x = 11'(lx); size_y = 11'(ly); size_z = 11'(lz);
    wg_id_x = ix; wg_id_y = iy; wg_id_z = iz; arg_ptr = p; cfg_word = cfg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    foreach (q[j]) begin
      check_entry(q[j]);
      if (inject && j == 4) begin
        start = 1'b1; size_x = 11'd7; arg_ptr = ~p; cfg_word = ~cfg;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (busy !== 1'b0 || wr_valid !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R7: after done busy=%0b valid=%0b done=%0b exp 0 0 0", busy, wr_valid, done);
    end
    if (inject) begin
      checks++;
      if (errors != err0) begin
        errors++;
        $display("FAIL R9: stream disturbed by start while busy, mismatches %0d exp 0", errors - err0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (busy !== 1'b0 || wr_valid !== 1'b0 || wave_start !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R10: busy%0b valid%0b ws%0b done%0b exp all 0", busy, wr_valid, wave_start, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_job(1, 1, 1, 32'h11, 32'h22, 32'h33, 64'h0123_4567_89AB_CDEF, 32'h0000_0380, 0); // R1 single lane
    run_job(32, 1, 1, 32'hA, 32'hB, 32'hC, 64'hDEAD_BEEF_0000_0042, 32'h0000_0282, 0);   // R1 exact wave
    run_job(33, 1, 1, 32'h1, 32'h2, 32'h3, 64'h1, 32'h0000_033E, 0);                     // R1 one-lane tail
    run_job(1024, 1, 1, 32'h7, 32'h8, 32'h9, 64'hFFFF_0000_FFFF_0000, 32'h0000_0100, 0); // R6
    run_job(1, 1, 1024, 32'h5, 32'h6, 32'h7, 64'h55, 32'h0000_0200, 0);                  // R6 z field
    run_job(3, 1024, 1, 32'h5, 32'h6, 32'h7, 64'h66, 32'h0000_0000, 0);                  // R6 y field
    run_job(0, 5, 5, 32'h1, 32'h1, 32'h1, 64'h1, 32'h0000_0380, 0);                      // R8
    run_job(4, 4, 0, 32'h1, 32'h1, 32'h1, 64'h1, 32'h0000_0380, 0);                      // R8
    run_job(5, 3, 2, 32'h77, 32'h88, 32'h99, 64'hCAFE_F00D_1234_5678, 32'h0000_0384, 1); // R9
    for (int r = 0; r < 16; r++) begin
      int lx, ly, lz;
      lx = 1 + int'($urandom % 20);
      ly = 1 + int'($urandom % 8);
      lz = 1 + int'($urandom % 4);
      run_job(lx, ly, lz, $urandom, $urandom, $urandom, {$urandom, $urandom}, $urandom, (r % 5) == 2);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule